// File: doc/BRIEF.md
# Complementary PWM Dual-Counter Timer

This block drives three pairs of complementary PWM pins, each pair separated by a dead-time gap so that the positive-phase and negative-phase pins of a pair are never high together. Two 16-bit up/down counters share one count enable. Each counter runs a triangle from 0 up to a common period value and back down. One counter starts ahead of the other by the dead-time value. For each pair, compare matches on the leading counter take a pin low, and matches on the lagging counter take the opposite pin high. Each edge of one pin is therefore followed, dead-time steps later, by the matching edge of the other pin.

Software programs the block through a simple write port. It sets the period, three compare points, the two counter preloads, per-pin output enables and an idle-level register. It enters the complementary mode and then sets both start bits. The block protects its configuration while counting: the mode and counter preloads cannot change while the counters run, and the mode cannot be re-entered without first being left.

Top module: `cpwm_timer`

## Requirements
- R1: After reset, `pwm_out` and `pwm_oe` are all 0 and the block is outside complementary mode.
- R2: A write of 2'b10 to bits [1:0] of the mode register (address 0) enters complementary mode only while counting is stopped and the idle-level register (address 9) is zero. On entry, the pins load positive-phase 0 and negative-phase 1. Bits [3:2] of that write, a counter-clear selection, have no effect.
- R3: Writing 2'b10 to the mode register while already in complementary mode does not re-initialise the pins. Leaving the mode with any other code and entering it again does re-initialise them.
- R4: Mode-register writes are ignored while the counters run.
- R5: Outside complementary mode, the six pin levels follow the idle-level register bits [5:0].
- R6: The counters advance by one step on a clock with `cnt_en` high, only when in complementary mode and with both start bits (address 1, bits [1:0]) set. Clearing either bit freezes both counters and all pins.
- R7: Each counter counts up to the period (address 2), then down to 0, then up again, giving 2*period steps per cycle. Counter 0 is preloaded from address 6 and counter 1 from address 7.
- R8: With compare value C for a pair, 0 < C < period, and a dead time D < C (counter 0 preload D, counter 1 preload 0), the negative-phase pin falls at step C-D+1 and the positive-phase pin rises at step C+1. The positive pin falls at step 2*period-C-D+1 and the negative pin rises at step 2*period-C+1, all taken modulo 2*period.
- R9: A compare value of 0 holds the pair at positive 0 and negative 1. A compare value at or above the period holds it at positive 1 and negative 0.
- R10: `pwm_oe` equals the output-enable register (address 8, bits [5:0]), and a pin whose enable bit is 0 drives 0.
- R11: Counter preload writes are ignored while the counters run.
- R12: Pin mapping: pair k (compare at address 3+k) uses bit 2k for the positive phase and bit 2k+1 for the negative phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Shared counter step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 6 | PWM pin levels after enable masking |
| pwm_oe | output | 6 | Per-pin output enables |

## Verification
A counter with a wrong direction, preload or turnaround moves a pin edge away from its predicted step index. The pins are compared with the step-index formula after every single step, so such a fault shows within one period of 2*period steps. A wrong mode flag shows within two clocks, because the pins then take the idle-level register instead of PWM levels. Dead-time errors show as a gap between a falling and the following rising edge that differs from the preload offset.

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [5:0]    pwm_out,
  output logic [5:0]    pwm_oe
);
  localparam int NP = 3;
  localparam logic [1:0] MODE_CPWM = 2'b10;
  localparam logic [AW-1:0] A_MODE  = AW'(0);
  localparam logic [AW-1:0] A_START = AW'(1);
  localparam logic [AW-1:0] A_PER   = AW'(2);
  localparam logic [AW-1:0] A_CMP0  = AW'(3);
  localparam logic [AW-1:0] A_CNT0  = AW'(6);
  localparam logic [AW-1:0] A_CNT1  = AW'(7);
  localparam logic [AW-1:0] A_OE    = AW'(8);
  localparam logic [AW-1:0] A_INIT  = AW'(9);

  logic         in_mode;
  logic [1:0]   start;
  logic [W-1:0] period;
  logic [W-1:0] cmp [NP];
  logic [W-1:0] c0, c1;
  logic         up0, up1;
  logic [5:0]   oe, init, st;

  wire running = in_mode & start[0] & start[1];
  wire step    = running & cnt_en;
  wire wr_mode = wr_en && wr_addr == A_MODE;
  wire enter   = wr_mode && wr_data[1:0] == MODE_CPWM && !in_mode && init == '0;
  wire leave   = wr_mode && wr_data[1:0] != MODE_CPWM && !running;

  function automatic logic [W:0] nxt(logic [W-1:0] c, logic up, logic [W-1:0] p);
    if (p == '0)      return {1'b1, {W{1'b0}}};
    else if (up)      return (c < p) ? {1'b1, c + 1'b1} : {1'b0, c - 1'b1};
    else if (c != '0) return {1'b0, c - 1'b1};
    else              return {1'b1, c + 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_mode <= 1'b0;
      start   <= '0;
      period  <= '0;
      oe      <= '0;
      init    <= '0;
      for (int i = 0; i < NP; i++) cmp[i] <= '0;
    end else begin
      if (enter) in_mode <= 1'b1;
      else if (leave) in_mode <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          A_START: start  <= wr_data[1:0];
          A_PER:   period <= wr_data;
          A_OE:    oe     <= wr_data[5:0];
          A_INIT:  init   <= wr_data[5:0];
          default: ;
        endcase
        for (int i = 0; i < NP; i++)
          if (wr_addr == A_CMP0 + AW'(i)) cmp[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0 <= '0; c1 <= '0; up0 <= 1'b1; up1 <= 1'b1;
    end else if (step) begin
      {up0, c0} <= nxt(c0, up0, period);
      {up1, c1} <= nxt(c1, up1, period);
    end else if (!running && wr_en) begin
      if (wr_addr == A_CNT0) begin c0 <= wr_data; up0 <= 1'b1; end
      if (wr_addr == A_CNT1) begin c1 <= wr_data; up1 <= 1'b1; end
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_pair
    logic pos_q, neg_q;
    wire m0 = c0 == cmp[g];
    wire m1 = c1 == cmp[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos_q <= 1'b0; neg_q <= 1'b0;
      end else if (enter) begin
        pos_q <= 1'b0; neg_q <= 1'b1;
      end else if (!in_mode) begin
        pos_q <= init[2*g]; neg_q <= init[2*g+1];
      end else if (cmp[g] == '0) begin
        pos_q <= 1'b0; neg_q <= 1'b1;
      end else if (cmp[g] >= period) begin
        pos_q <= 1'b1; neg_q <= 1'b0;
      end else if (step) begin
        if (m0 && up0)  neg_q <= 1'b0;
        if (m1 && !up1) neg_q <= 1'b1;
        if (m0 && !up0) pos_q <= 1'b0;
        if (m1 && up1)  pos_q <= 1'b1;
      end
    end

    assign st[2*g]   = pos_q;
    assign st[2*g+1] = neg_q;

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_mode |-> !(pos_q && neg_q));
    assert_zero_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_mode && cmp[g] == '0 |=> !in_mode || (!pos_q && neg_q));
    assert_full_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_mode && cmp[g] != '0 && cmp[g] >= period |=> !in_mode || (pos_q && !neg_q));
  end

  assign pwm_out = st & oe;
  assign pwm_oe  = oe;

  assert_entry_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_mode) |-> st == 6'b101010);
  assert_mode_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> in_mode);
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !(wr_en && (wr_addr == A_CNT0 || wr_addr == A_CNT1))
    |=> $stable(c0) && $stable(c1));
  assert_turn_at_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step && up0 && c0 < period |=> up0);
endmodule

// File: tb/sim_cpwm_timer.sv
module sim_cpwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int P = 10, C = 5, D = 2;

  logic        clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pwm_out, pwm_oe;
  int checks = 0, fails = 0, k = 0;
  bit done = 1'b0;

  cpwm_timer u0 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
                 .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b (step %0d)", req, act, exp, k);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step1();
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  function automatic logic [5:0] expect_at(int n);
    int m = n % (2*P);
    logic pos = (m >= C+1) && (m <= 2*P-C-D);
    logic neg = !((m >= C-D+1) && (m <= 2*P-C));
    return {2'b01, 2'b10, neg, pos};
  endfunction

  task automatic run_steps(int n, string req);
    for (int i = 0; i < n; i++) begin
      step1(); k++;
      chk(req, pwm_out, expect_at(k));
    end
  endtask

  task automatic t_reset();
    chk("R1 out", pwm_out, 6'h00);
    chk("R1 oe", pwm_oe, 6'h00);
  endtask

  task automatic t_entry();
    wr(4'd8, 16'h003F); idle(1);
    chk("R10 oe", pwm_oe, 6'h3F);
    wr(4'd9, 16'h0005); idle(1);
    chk("R5 idle levels", pwm_out, 6'h05);
    wr(4'd0, 16'h0002); idle(1);
    chk("R2 entry blocked by idle reg", pwm_out, 6'h05);
    wr(4'd9, 16'h0000); idle(1);
    chk("R5 idle zero", pwm_out, 6'h00);
    wr(4'd0, 16'h000E); idle(1);
    chk("R2 entry init", pwm_out, 6'b101010);
  endtask

  task automatic t_config();
    wr(4'd2, 16'(P));
    wr(4'd3, 16'(C));
    wr(4'd4, 16'd0);
    wr(4'd5, 16'(P + 2));
    wr(4'd6, 16'(D));
    wr(4'd7, 16'd0);
    idle(2);
    chk("R9 forced duty R12 mapping", pwm_out, 6'b011010);
  endtask

  task automatic t_run();
    int fall_n = -1, rise_p = -1, fall_p = -1, rise_n = -1;
    logic [5:0] prev;
    wr(4'd1, 16'h0001);
    for (int i = 0; i < 5; i++) begin
      step1();
      chk("R6 one start bit", pwm_out, 6'b011010);
    end
    wr(4'd1, 16'h0003);
    prev = pwm_out;
    for (int i = 0; i < 45; i++) begin
      step1(); k++;
      chk("R7 waveform", pwm_out, expect_at(k));
      if (prev[1] && !pwm_out[1] && fall_n < 0) fall_n = k;
      if (!prev[0] && pwm_out[0] && rise_p < 0) rise_p = k;
      if (prev[0] && !pwm_out[0] && fall_p < 0) fall_p = k;
      if (!prev[1] && pwm_out[1] && rise_n < 0) rise_n = k;
      prev = pwm_out;
    end
    chk("R8 rising gap", 6'(rise_p - fall_n), 6'(D));
    chk("R8 falling gap", 6'(rise_n - fall_p), 6'(D));
  endtask

  task automatic t_stall();
    logic [5:0] hold = pwm_out;
    idle(7);
    chk("R6 cnt_en low", pwm_out, hold);
    run_steps(6, "R6 resume");
  endtask

  task automatic t_locked();
    wr(4'd9, 16'h003F);
    wr(4'd0, 16'h0000); idle(2);
    chk("R4 mode write ignored", pwm_out, expect_at(k));
    run_steps(8, "R4 still pwm");
    wr(4'd6, 16'd7);
    wr(4'd7, 16'd7);
    run_steps(25, "R11 preload ignored");
  endtask

  task automatic t_stop();
    logic [5:0] hold;
    wr(4'd1, 16'h0002);
    hold = pwm_out;
    for (int i = 0; i < 5; i++) step1();
    chk("R6 start bit cleared", pwm_out, hold);
    wr(4'd1, 16'h0003);
    run_steps(10, "R6 restart");
  endtask

  task automatic t_reenter();
    for (int i = 0; i < 40 && expect_at(k)[0] !== 1'b1; i++) begin
      step1(); k++;
    end
    chk("R3 precondition", pwm_out, expect_at(k));
    wr(4'd1, 16'h0000);
    wr(4'd0, 16'h0002); idle(2);
    chk("R3 reselect no effect", pwm_out, expect_at(k));
    wr(4'd0, 16'h0001); idle(2);
    chk("R5 leave to idle levels", pwm_out, 6'h3F);
    wr(4'd9, 16'h0000);
    wr(4'd0, 16'h0002); idle(2);
    chk("R3 re-entry init", pwm_out, 6'b011010);
  endtask

  task automatic t_mask();
    wr(4'd8, 16'h0003); idle(1);
    chk("R10 enable mask", pwm_out, 6'b000010);
    chk("R10 oe port", pwm_oe, 6'b000011);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_entry();
    t_config();
    t_run();
    t_stall();
    t_locked();
    t_stop();
    t_reenter();
    t_mask();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule